// File: doc/BRIEF.md
# Crosstalk-avoiding double-error-correcting flit codec

This block protects a 32-bit network-on-chip flit on its way across an inter-switch link. The encoder first builds a 38-bit Hamming word. It then places each bit of that word on two neighbouring wires and adds a single even-parity wire over the Hamming word, for 77 wires in all. Neighbouring wires always carry equal values, so no wire can switch against both of its neighbours in the same transition. The overall code has a minimum distance of 7.

The decoder splits the received wires into two 38-bit copies: the even wires and the odd wires. It checks the syndrome of each copy and the parity of each copy against the parity wire. From these it chooses which copy to trust, and it repairs any single bit still wrong in that copy. It returns the flit, a flag that says some error was seen, and a flag that says the chosen copy's syndrome named no existing position.

The encoder path and the decoder path are independent. Each one is a single combinational stage followed by a register that a parameter can remove. In a switch, the encoder sits at the sending port and the decoder at the receiving port.

Top module: `xdc_codec`

## Requirements
- R1: The Hamming word uses positions 1 to 38. Check bits sit at positions 1, 2, 4, 8, 16 and 32. Flit bits 0 to 31 fill the other positions in ascending order, so flit bit 0 is at position 3 and flit bit 31 at position 38.
- R2: The check bit at position 2^j is chosen so that the XOR of all set position numbers (the syndrome) of an encoded word is zero.
- R3: The Hamming bit at position p drives both wire 2(p-1) and wire 2(p-1)+1, so every even/odd wire pair of the encoder output is equal.
- R4: Wire 76 of the encoder output carries the XOR of the 38 Hamming bits.
- R5: When the decoder receives an error-free codeword, it returns the original flit with both flags low.
- R6: After an inversion of any one of the 77 wires, the decoder returns the original flit with the corrected flag high and the uncorrectable flag low.
- R7: After inversions of any two distinct wires, the decoder returns the original flit with the corrected flag high and the uncorrectable flag low.
- R8: The decoder picks a copy in this order: a copy with zero syndrome whose parity matches wire 76, else a copy with zero syndrome, else the copy whose parity matches wire 76 (the odd copy if none matches). If the chosen copy's syndrome is above 38, the uncorrectable flag rises, and it is raised only together with the corrected flag.
- R9: With the output register on (the default), each path's valid output repeats its valid input one clock later, and the result belongs to that input. Reset clears both valid outputs.
- R10: The encoder and decoder paths accept inputs in the same cycle and do not influence each other's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Flit to encode is present |
| enc_data_i | input | 32 | Flit to encode |
| enc_valid_o | output | 1 | Encoded word is present |
| enc_word_o | output | 77 | Encoded wires |
| dec_valid_i | input | 1 | Received word is present |
| dec_word_i | input | 77 | Received wires |
| dec_valid_o | output | 1 | Decoded flit is present |
| dec_data_o | output | 32 | Decoded flit |
| dec_corrected_o | output | 1 | An error was seen in the received word |
| dec_uncorrectable_o | output | 1 | The chosen copy's syndrome named no position |

## Verification
The encoder and the decoder can both produce a result in the same cycle. The bench therefore feeds both paths in nearly every cycle with unrelated traffic: clean, single-error and double-error words go to the decoder while walking-one and random flits go to the encoder. Each path has its own expected queue, and every result is matched against the item queued for it in the cycle before. A result that appears on the wrong path, or in a cycle with no input, shows up as a mismatch or as an output with nothing queued.

// File: rtl/xdc_pkg.sv
package xdc_pkg;

    localparam int DATA_W   = 32;
    localparam int CHK_W    = 6;
    localparam int HAM_W    = DATA_W + CHK_W;
    localparam int WIRE_W   = 2 * HAM_W + 1;
    localparam int PAR_WIRE = WIRE_W - 1;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [HAM_W-1:0]  ham_t;   // bit k holds Hamming position k+1
    typedef logic [WIRE_W-1:0] wire_t;
    typedef logic [CHK_W-1:0]  syn_t;

    typedef struct packed {
        data_t data;
        logic  corrected;
        logic  uncorrectable;
    } dec_res_t;

    typedef enum logic [2:0] {
        PK_A_CLEAN,
        PK_B_CLEAN,
        PK_A_ZERO,
        PK_B_ZERO,
        PK_A_FIX,
        PK_B_FIX
    } pick_t;

    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic syn_t ham_syndrome(input ham_t h);
        syn_t s;
        s = '0;
        for (int p = 1; p <= HAM_W; p++) begin
            if (h[p-1]) s = s ^ syn_t'(p);
        end
        return s;
    endfunction

    function automatic ham_t ham_encode(input data_t d);
        ham_t h;
        syn_t s;
        int   k;
        h = '0;
        k = 0;
        for (int p = 1; p <= HAM_W; p++) begin
            if (!is_pow2(p)) begin
                h[p-1] = d[k];
                k = k + 1;
            end
        end
        s = ham_syndrome(h);
        for (int j = 0; j < CHK_W; j++) begin
            h[(1 << j) - 1] = s[j];
        end
        return h;
    endfunction

    function automatic data_t ham_extract(input ham_t h);
        data_t d;
        int    k;
        d = '0;
        k = 0;
        for (int p = 1; p <= HAM_W; p++) begin
            if (!is_pow2(p)) begin
                d[k] = h[p-1];
                k = k + 1;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/xdc_stage.sv
module xdc_stage #(
    parameter int W      = 1,
    parameter bit ENABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid_i,
    input  logic [W-1:0] data_i,
    output logic         valid_o,
    output logic [W-1:0] data_o
);

    generate
        if (ENABLE) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    valid_o <= 1'b0;
                    data_o  <= '0;
                end else begin
                    valid_o <= valid_i;
                    data_o  <= data_i;
                end
            end

            // R9: one-cycle latency of the valid strobe
            a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
                valid_i |=> valid_o);
            a_r9_idle_follows: assert property (@(posedge clk) disable iff (rst)
                !valid_i |=> !valid_o);
        end else begin : g_pass
            assign valid_o = valid_i;
            assign data_o  = data_i;
        end
    endgenerate

endmodule

// File: rtl/xdc_encoder.sv
module xdc_encoder
    import xdc_pkg::*;
(
    input  data_t data_i,
    output wire_t word_o
);

    ham_t ham;
    assign ham = ham_encode(data_i);

    generate
        for (genvar i = 0; i < HAM_W; i++) begin : g_dup
            assign word_o[2*i]     = ham[i];
            assign word_o[2*i + 1] = ham[i];
        end
    endgenerate

    assign word_o[PAR_WIRE] = ^ham;

endmodule

// File: rtl/xdc_decoder.sv
module xdc_decoder
    import xdc_pkg::*;
(
    input  wire_t    word_i,
    output dec_res_t res_o
);

    ham_t  cp_a;
    ham_t  cp_b;
    logic  par_w;
    syn_t  syn_a;
    syn_t  syn_b;
    logic  pm_a;
    logic  pm_b;
    pick_t pick;
    logic  take_b;
    ham_t  chosen;
    syn_t  syn_c;
    ham_t  fixed;

    generate
        for (genvar i = 0; i < HAM_W; i++) begin : g_split
            assign cp_a[i] = word_i[2*i];
            assign cp_b[i] = word_i[2*i + 1];
        end
    endgenerate

    assign par_w = word_i[PAR_WIRE];

    always_comb begin
        syn_a = ham_syndrome(cp_a);
        syn_b = ham_syndrome(cp_b);
        pm_a  = (^cp_a) == par_w;
        pm_b  = (^cp_b) == par_w;

        if (syn_a == '0 && pm_a)      pick = PK_A_CLEAN;
        else if (syn_b == '0 && pm_b) pick = PK_B_CLEAN;
        else if (syn_a == '0)         pick = PK_A_ZERO;
        else if (syn_b == '0)         pick = PK_B_ZERO;
        else if (pm_a)                pick = PK_A_FIX;
        else                          pick = PK_B_FIX;

        take_b = (pick == PK_B_CLEAN) || (pick == PK_B_ZERO) || (pick == PK_B_FIX);
        chosen = take_b ? cp_b : cp_a;
        syn_c  = take_b ? syn_b : syn_a;

        fixed = chosen;
        if (syn_c != '0 && int'(syn_c) <= HAM_W) begin
            fixed[int'(syn_c) - 1] = ~chosen[int'(syn_c) - 1];
        end

        res_o.data          = ham_extract(fixed);
        res_o.corrected     = (cp_a != cp_b) || (syn_a != '0) || !pm_a;
        res_o.uncorrectable = int'(syn_c) > HAM_W;
    end

endmodule

// File: rtl/xdc_codec.sv
module xdc_codec
    import xdc_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enc_valid_i,
    input  logic [31:0]  enc_data_i,
    output logic         enc_valid_o,
    output logic [76:0]  enc_word_o,
    input  logic         dec_valid_i,
    input  logic [76:0]  dec_word_i,
    output logic         dec_valid_o,
    output logic [31:0]  dec_data_o,
    output logic         dec_corrected_o,
    output logic         dec_uncorrectable_o
);

    localparam int RES_W = $bits(dec_res_t);

    wire_t    enc_word_c;
    dec_res_t dec_res_c;
    dec_res_t dec_res_q;

    xdc_encoder u_enc (
        .data_i (enc_data_i),
        .word_o (enc_word_c)
    );

    xdc_stage #(.W(WIRE_W), .ENABLE(OUT_REG)) u_enc_stage (
        .clk     (clk),
        .rst     (rst),
        .valid_i (enc_valid_i),
        .data_i  (enc_word_c),
        .valid_o (enc_valid_o),
        .data_o  (enc_word_o)
    );

    xdc_decoder u_dec (
        .word_i (dec_word_i),
        .res_o  (dec_res_c)
    );

    xdc_stage #(.W(RES_W), .ENABLE(OUT_REG)) u_dec_stage (
        .clk     (clk),
        .rst     (rst),
        .valid_i (dec_valid_i),
        .data_i  (dec_res_c),
        .valid_o (dec_valid_o),
        .data_o  (dec_res_q)
    );

    assign dec_data_o          = dec_res_q.data;
    assign dec_corrected_o     = dec_res_q.corrected;
    assign dec_uncorrectable_o = dec_res_q.uncorrectable;

    // output-side views of the two wire copies for the checks below
    ham_t out_even;
    ham_t out_odd;
    generate
        for (genvar i = 0; i < HAM_W; i++) begin : g_view
            assign out_even[i] = enc_word_o[2*i];
            assign out_odd[i]  = enc_word_o[2*i + 1];
        end
    endgenerate

    a_r3_pairs_equal: assert property (@(posedge clk) disable iff (rst)
        enc_valid_o |-> (out_even == out_odd));

    a_r4_parity_wire: assert property (@(posedge clk) disable iff (rst)
        enc_valid_o |-> (enc_word_o[PAR_WIRE] == ^out_even));

    a_r8_unc_with_corr: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_o && dec_uncorrectable_o) |-> dec_corrected_o);

endmodule

// File: tb/tb_xdc_codec.sv
`timescale 1ns/1ps
module tb_xdc_codec;
    import xdc_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        enc_valid_i;
    logic [31:0] enc_data_i;
    logic        enc_valid_o;
    logic [76:0] enc_word_o;
    logic        dec_valid_i;
    logic [76:0] dec_word_i;
    logic        dec_valid_o;
    logic [31:0] dec_data_o;
    logic        dec_corrected_o;
    logic        dec_uncorrectable_o;

    always #10 clk = ~clk;

    xdc_codec #(.OUT_REG(1'b1)) dut (
        .clk                 (clk),
        .rst                 (rst),
        .enc_valid_i         (enc_valid_i),
        .enc_data_i          (enc_data_i),
        .enc_valid_o         (enc_valid_o),
        .enc_word_o          (enc_word_o),
        .dec_valid_i         (dec_valid_i),
        .dec_word_i          (dec_word_i),
        .dec_valid_o         (dec_valid_o),
        .dec_data_o          (dec_data_o),
        .dec_corrected_o     (dec_corrected_o),
        .dec_uncorrectable_o (dec_uncorrectable_o)
    );

    typedef struct packed {
        logic [31:0] data;
        logic        corr;
        logic        unc;
        logic        chk_data;
    } dexp_t;

    logic [76:0] enc_q[$];
    dexp_t       dec_q[$];
    string       dec_tag_q[$];
    int checks = 0;
    int errors = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %s expected %s", req, act, exp);
        end
    endtask

    // independent model of the wire mapping (R1 R2 R3 R4)
    function automatic logic [76:0] m_enc(input logic [31:0] d);
        logic [38:1] pos;
        logic [76:0] w;
        logic        par;
        int          k;
        pos = '0;
        k = 0;
        for (int p = 1; p <= 38; p++) begin
            if ((p & (p - 1)) != 0) begin
                pos[p] = d[k];
                k = k + 1;
            end
        end
        for (int j = 0; j < 6; j++) begin
            logic b;
            b = 1'b0;
            for (int p = 1; p <= 38; p++) begin
                if (((p >> j) & 1) == 1 && p != (1 << j)) b = b ^ pos[p];
            end
            pos[1 << j] = b;
        end
        w = '0;
        par = 1'b0;
        for (int p = 1; p <= 38; p++) begin
            w[2*(p-1)]   = pos[p];
            w[2*(p-1)+1] = pos[p];
            par = par ^ pos[p];
        end
        w[76] = par;
        return w;
    endfunction

    // driver: one cycle of stimulus on both paths, expectations queued
    task automatic drive(input logic ev, input logic [31:0] ed,
                         input logic dv, input logic [76:0] dw,
                         input dexp_t ex, input string tag);
        @(negedge clk);
        enc_valid_i = ev;
        enc_data_i  = ed;
        dec_valid_i = dv;
        dec_word_i  = dw;
        if (ev) enc_q.push_back(m_enc(ed));
        if (dv) begin
            dec_q.push_back(ex);
            dec_tag_q.push_back(tag);
        end
    endtask

    function automatic dexp_t mk(input logic [31:0] d, input logic c, input logic u, input logic cd);
        dexp_t e;
        e.data = d; e.corr = c; e.unc = u; e.chk_data = cd;
        return e;
    endfunction

    // monitor: compares results one step after the driving edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst) begin
                if (enc_valid_o) begin
                    if (enc_q.size() == 0) begin
                        chk(0, "R9 enc valid with nothing queued", "valid", "idle");
                    end else begin
                        logic [76:0] e;
                        e = enc_q.pop_front();
                        chk(enc_word_o == e, "R1 R2 R3 R4 R10 encoder word",
                            $sformatf("%h", enc_word_o), $sformatf("%h", e));
                    end
                end
                if (dec_valid_o) begin
                    if (dec_q.size() == 0) begin
                        chk(0, "R9 dec valid with nothing queued", "valid", "idle");
                    end else begin
                        dexp_t e;
                        string t;
                        e = dec_q.pop_front();
                        t = dec_tag_q.pop_front();
                        if (e.chk_data)
                            chk(dec_data_o == e.data, {t, " data"},
                                $sformatf("%h", dec_data_o), $sformatf("%h", e.data));
                        chk(dec_corrected_o == e.corr && dec_uncorrectable_o == e.unc,
                            {t, " flags corr/unc"},
                            $sformatf("%b%b", dec_corrected_o, dec_uncorrectable_o),
                            $sformatf("%b%b", e.corr, e.unc));
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [76:0] w;
        rst = 1'b1;
        enc_valid_i = 1'b0; enc_data_i = '0;
        dec_valid_i = 1'b0; dec_word_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(enc_valid_o == 1'b0 && dec_valid_o == 1'b0, "R9 reset clears valids",
            $sformatf("%b%b", enc_valid_o, dec_valid_o), "00");
        chk(enc_word_o == '0 && dec_data_o == '0, "R9 reset clears data",
            $sformatf("%h/%h", enc_word_o, dec_data_o), "0/0");
        rst = 1'b0;

        // clean words on the decoder while the encoder sees directed flits (R5 R10)
        drive(1, 32'h0000_0000, 1, m_enc(32'hFFFF_FFFF), mk(32'hFFFF_FFFF, 0, 0, 1), "R5 clean ones");
        drive(1, 32'hFFFF_FFFF, 1, m_enc(32'h0000_0000), mk(32'h0000_0000, 0, 0, 1), "R5 clean zero");
        drive(1, 32'hA5A5_5A5A, 1, m_enc(32'h1234_5678), mk(32'h1234_5678, 0, 0, 1), "R5 clean mix");
        for (int i = 0; i < 32; i++) begin
            d = 32'h1 << i;
            drive(1, d, 1, m_enc(~d), mk(~d, 0, 0, 1), "R5 R10 walking");
        end

        // idle gap: nothing must emerge (R9)
        repeat (4) drive(0, 32'hDEAD_BEEF, 0, '0, mk('0, 0, 0, 0), "idle");
        @(negedge clk);
        chk(enc_q.size() == 0 && dec_q.size() == 0, "R9 queues drained after gap",
            $sformatf("%0d/%0d", enc_q.size(), dec_q.size()), "0/0");

        // every single-wire error (R6)
        d = 32'hC3A5_0F96;
        for (int a = 0; a < 77; a++) begin
            w = m_enc(d);
            w[a] = ~w[a];
            drive(1, $urandom, 1, w, mk(d, 1, 0, 1), $sformatf("R6 single wire %0d", a));
        end

        // every double-wire error (R7 R8)
        d = 32'h5EED_1234;
        for (int a = 0; a < 77; a++) begin
            for (int b = a + 1; b < 77; b++) begin
                w = m_enc(d);
                w[a] = ~w[a];
                w[b] = ~w[b];
                drive((a + b) % 3 != 0, $urandom, 1, w, mk(d, 1, 0, 1),
                      $sformatf("R7 R8 double wires %0d %0d", a, b));
            end
        end

        // random data with zero, one or two random errors
        for (int n = 0; n < 400; n++) begin
            int unsigned ne;
            int unsigned a;
            int unsigned b;
            d  = $urandom;
            ne = $urandom_range(2, 0);
            w  = m_enc(d);
            a  = $urandom_range(76, 0);
            b  = (a + $urandom_range(75, 1)) % 77;
            if (ne >= 1) w[a] = ~w[a];
            if (ne == 2) w[b] = ~w[b];
            drive(n % 5 != 0, $urandom, n % 7 != 0, w, mk(d, ne != 0, 0, 1), "R5 R6 R7 random");
        end

        // both copies hit at positions 7 and 32: each syndrome is 39 (R8)
        w = m_enc(32'h0BAD_F00D);
        w[12] = ~w[12]; w[13] = ~w[13];
        w[62] = ~w[62]; w[63] = ~w[63];
        drive(1, 32'h0, 1, w, mk('0, 1, 1, 0), "R8 syndrome beyond word");

        repeat (3) drive(0, '0, 0, '0, mk('0, 0, 0, 0), "idle");
        @(negedge clk);
        chk(enc_q.size() == 0 && dec_q.size() == 0, "R9 all results delivered",
            $sformatf("%0d/%0d", enc_q.size(), dec_q.size()), "0/0");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule